// File: doc/BRIEF.md
# Single-Wire Debug Sync Responder

This block sits on the target side of an open-drain, single-wire debug line. The host announces a speed measurement by holding the line low for a long time. The block counts that low time in debug-clock ticks. Once the count reaches a programmable threshold, it drops whatever serial transfer was in progress by pulsing a soft-reset strobe. If the host was waiting for an acknowledge, it also pulses an abort strobe.

The block then waits until the host lets the line go high. It leaves a fixed quiet gap so the host can remove its own high speedup drive. After the gap it pulls the line low for exactly 128 debug ticks, drives it high for one tick to give a sharp rising edge, and releases the pad. The host times that low pulse to work out the target's serial bit rate.

Every debug tick is marked by a one-cycle enable supplied from outside. In the intended system that enable runs at one eighth of the oscillator rate. The line is read through a two-stage synchroniser. The block masks its own drive out of the sampled copy. When no response is in progress, it reports each falling edge from the host, so the command decoder can start a new frame.

Top module: `bgs_sync_resp`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `pad_oe`, `pad_out`, `soft_rst`, `ack_abort` and `host_fall` are all 0.
- R2: A host low lasting at least `sync_thresh` debug ticks gives exactly one single-cycle `soft_rst` pulse. A host low shorter than `sync_thresh` gives none and causes no drive.
- R3: The low-time counter (`CW` bits) saturates at its all-ones value. A low held far longer than 2^CW ticks still gives exactly one `soft_rst` pulse and one normal response.
- R4: The block never drives the pad while the host holds the line low. After the line is seen high, it waits `GAP_LEN` (16) debug ticks before it starts driving.
- R5: The response begins with `pad_oe`=1 and `pad_out`=0. This low drive lasts exactly `LOW_LEN` (128) debug ticks.
- R6: The low drive is followed by exactly one debug tick of `pad_oe`=1, `pad_out`=1, after which `pad_oe` returns to 0.
- R7: `ack_abort` pulses in the same cycle as `soft_rst` if `ack_pend` is 1, and stays 0 if `ack_pend` is 0.
- R8: `host_fall` pulses once for each falling edge the host makes while no response is in progress. The block's own drive never produces a `host_fall` pulse.
- R9: After a response completes, the next host low is measured from its falling edge. A second sync request can therefore follow immediately and receives a full response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| dbg_ce | input | 1 | One-cycle enable marking each debug-clock tick |
| line_in | input | 1 | Raw level read from the debug pad |
| sync_thresh | input | CW | Minimum low time, in debug ticks, that counts as a sync request |
| ack_pend | input | 1 | High while an acknowledge pulse is owed to the host |
| pad_oe | output | 1 | Pad output enable; 0 leaves the line to the pull-up |
| pad_out | output | 1 | Level driven while `pad_oe` is 1 |
| soft_rst | output | 1 | Single-cycle strobe that discards a partial command |
| ack_abort | output | 1 | Single-cycle strobe that cancels a pending acknowledge |
| host_fall | output | 1 | Single-cycle strobe on a host falling edge while idle |

## Verification
The assertions assume four things about the inputs. First, `dbg_ce` is a periodic one-cycle strobe. Second, the host never pulls the line low while the pad is enabled. Third, `ack_pend` holds its value for at least one cycle around a detection. Fourth, `sync_thresh` is at least 1. The bench models the line as a wired connection in which the host drives low only while `pad_oe` is 0. It generates `dbg_ce` from a fixed divider. It changes `sync_thresh` and `ack_pend` only between requests. It keeps every random low length at least two ticks away from the threshold, so the two-stage synchroniser cannot make the expected outcome ambiguous.

// File: rtl/bgs_pkg.sv
package bgs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_WAIT_HI = 3'd1,
    ST_GAP     = 3'd2,
    ST_LOW     = 3'd3,
    ST_SPEED   = 3'd4
  } resp_st_t;

  function automatic int unsigned cnt_bits(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/bgs_line_sampler.sv
module bgs_line_sampler #(
  parameter int STAGES = 2,
  parameter int BLANK  = STAGES + 1
) (
  input  logic clk,
  input  logic rst,
  input  logic line_in,
  input  logic own_drive,
  output logic line_q,
  output logic fall
);
  localparam int BW = $clog2(BLANK + 1);

  logic [STAGES-1:0] sh;
  logic [BW-1:0]     blank;
  logic              nl;

  // Own drive and its echo through the synchroniser read as released (high).
  always_comb nl = (own_drive || blank != '0) ? 1'b1 : sh[STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      sh     <= '1;
      blank  <= '0;
      line_q <= 1'b1;
      fall   <= 1'b0;
    end else begin
      sh     <= {sh[STAGES-2:0], line_in};
      if (own_drive)
        blank <= BW'(BLANK);
      else if (blank != '0)
        blank <= blank - 1'b1;
      fall   <= line_q & ~nl;
      line_q <= nl;
    end
  end
endmodule

// File: rtl/bgs_low_timer.sv
module bgs_low_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ce,
  input  logic          line_q,
  input  logic          arm,
  input  logic [CW-1:0] thresh,
  output logic          hit
);
  logic [CW-1:0] cnt;
  logic          fired;
  logic [CW:0]   cnt_next;

  always_comb cnt_next = {1'b0, cnt} + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      fired <= 1'b0;
      hit   <= 1'b0;
    end else begin
      hit <= 1'b0;
      if (line_q) begin
        cnt   <= '0;
        fired <= 1'b0;
      end else if (ce) begin
        if (cnt != '1)
          cnt <= cnt + 1'b1;
        if (arm && !fired && cnt_next >= {1'b0, thresh}) begin
          hit   <= 1'b1;
          fired <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/bgs_resp_fsm.sv
module bgs_resp_fsm
  import bgs_pkg::*;
#(
  parameter int GAP_LEN = 16,
  parameter int LOW_LEN = 128
) (
  input  logic clk,
  input  logic rst,
  input  logic ce,
  input  logic hit,
  input  logic line_q,
  input  logic ack_pend,
  output logic idle,
  output logic pad_oe,
  output logic pad_out,
  output logic soft_rst,
  output logic ack_abort
);
  localparam int LONGEST = (GAP_LEN > LOW_LEN) ? GAP_LEN : LOW_LEN;
  localparam int TW      = cnt_bits(LONGEST);

  resp_st_t      st;
  logic [TW-1:0] tcnt;

  always_comb idle = (st == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      tcnt      <= '0;
      pad_oe    <= 1'b0;
      pad_out   <= 1'b0;
      soft_rst  <= 1'b0;
      ack_abort <= 1'b0;
    end else begin
      soft_rst  <= 1'b0;
      ack_abort <= 1'b0;
      unique case (st)
        ST_IDLE: if (hit) begin
          st        <= ST_WAIT_HI;
          soft_rst  <= 1'b1;
          ack_abort <= ack_pend;
        end
        ST_WAIT_HI: if (line_q) begin
          st   <= ST_GAP;
          tcnt <= '0;
        end
        ST_GAP: if (ce) begin
          if (tcnt == TW'(GAP_LEN - 1)) begin
            st      <= ST_LOW;
            tcnt    <= '0;
            pad_oe  <= 1'b1;
            pad_out <= 1'b0;
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
        ST_LOW: if (ce) begin
          if (tcnt == TW'(LOW_LEN - 1)) begin
            st      <= ST_SPEED;
            pad_out <= 1'b1;
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
        ST_SPEED: if (ce) begin
          st      <= ST_IDLE;
          pad_oe  <= 1'b0;
          pad_out <= 1'b0;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bgs_sync_resp.sv
module bgs_sync_resp #(
  parameter int CW          = 8,
  parameter int GAP_LEN     = 16,
  parameter int LOW_LEN     = 128,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          dbg_ce,
  input  logic          line_in,
  input  logic [CW-1:0] sync_thresh,
  input  logic          ack_pend,
  output logic          pad_oe,
  output logic          pad_out,
  output logic          soft_rst,
  output logic          ack_abort,
  output logic          host_fall
);
  logic line_q, fall, hit, idle;

  bgs_line_sampler #(.STAGES(SYNC_STAGES)) u_samp (
    .clk(clk), .rst(rst), .line_in(line_in), .own_drive(pad_oe),
    .line_q(line_q), .fall(fall)
  );

  bgs_low_timer #(.CW(CW)) u_tmr (
    .clk(clk), .rst(rst), .ce(dbg_ce), .line_q(line_q), .arm(idle),
    .thresh(sync_thresh), .hit(hit)
  );

  bgs_resp_fsm #(.GAP_LEN(GAP_LEN), .LOW_LEN(LOW_LEN)) u_fsm (
    .clk(clk), .rst(rst), .ce(dbg_ce), .hit(hit), .line_q(line_q),
    .ack_pend(ack_pend), .idle(idle), .pad_oe(pad_oe), .pad_out(pad_out),
    .soft_rst(soft_rst), .ack_abort(ack_abort)
  );

  always_ff @(posedge clk) begin
    if (rst) host_fall <= 1'b0;
    else     host_fall <= fall & idle;
  end
endmodule

// File: rtl/bgs_sync_resp_chk.sv
module bgs_sync_resp_chk (
  input logic clk,
  input logic rst,
  input logic dbg_ce,
  input logic ack_pend,
  input logic pad_oe,
  input logic pad_out,
  input logic soft_rst,
  input logic ack_abort,
  input logic host_fall
);
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!pad_oe && !pad_out && !soft_rst && !ack_abort && !host_fall));

  a_r2_single_strobe: assert property (@(posedge clk) disable iff (rst)
    soft_rst |=> !soft_rst);

  a_r4_no_drive_at_detect: assert property (@(posedge clk) disable iff (rst)
    soft_rst |-> !pad_oe);

  a_r5_starts_low: assert property (@(posedge clk) disable iff (rst)
    $rose(pad_oe) |-> !pad_out);

  a_r5_low_holds_between_ticks: assert property (@(posedge clk) disable iff (rst)
    (pad_oe && !pad_out && !dbg_ce) |=> (pad_oe && !pad_out));

  a_r6_one_high_tick: assert property (@(posedge clk) disable iff (rst)
    (pad_oe && pad_out && dbg_ce) |=> !pad_oe);

  a_r6_release_after_high: assert property (@(posedge clk) disable iff (rst)
    $fell(pad_oe) |-> $past(pad_out));

  a_r7_abort_with_reset: assert property (@(posedge clk) disable iff (rst)
    ack_abort |-> (soft_rst && $past(ack_pend)));

  a_r8_fall_not_own: assert property (@(posedge clk) disable iff (rst)
    host_fall |-> (!pad_oe && !$past(pad_oe)));
endmodule

bind bgs_sync_resp bgs_sync_resp_chk u_chk (
  .clk(clk), .rst(rst), .dbg_ce(dbg_ce), .ack_pend(ack_pend),
  .pad_oe(pad_oe), .pad_out(pad_out), .soft_rst(soft_rst),
  .ack_abort(ack_abort), .host_fall(host_fall)
);

// File: tb/sim_bgs_sync_resp.sv
module sim_bgs_sync_resp;
  localparam int CW = 8, GAP_LEN = 16, LOW_LEN = 128, DIV = 4;

  logic clk = 1'b0, rst = 1'b1, dbg_ce = 1'b0, host_low = 1'b0, ack_pend = 1'b0;
  logic [CW-1:0] sync_thresh = 8'd128;
  logic line_in, pad_oe, pad_out, soft_rst, ack_abort, host_fall;
  int n_chk = 0, n_fail = 0;
  int n_soft = 0, n_abort = 0, n_fall = 0, n_clash = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  assign line_in = pad_oe ? pad_out : ~host_low;

  bgs_sync_resp #(.CW(CW), .GAP_LEN(GAP_LEN), .LOW_LEN(LOW_LEN)) u0 (
    .clk(clk), .rst(rst), .dbg_ce(dbg_ce), .line_in(line_in),
    .sync_thresh(sync_thresh), .ack_pend(ack_pend), .pad_oe(pad_oe),
    .pad_out(pad_out), .soft_rst(soft_rst), .ack_abort(ack_abort),
    .host_fall(host_fall)
  );

  initial begin
    int dc = 0;
    forever begin
      @(negedge clk);
      dbg_ce = (dc == 0);
      dc = (dc + 1) % DIV;
    end
  end

  always @(negedge clk) if (!rst) begin
    if (soft_rst)  n_soft++;
    if (ack_abort) n_abort++;
    if (host_fall) n_fall++;
    if (host_low && pad_oe) n_clash++;
  end

  function automatic bit exp_detect(input int len, input int thr);
    return len >= thr;
  endfunction

  task automatic check(input bit ok, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic run_trial(input int len, input int thr, input bit ackp, input string tag);
    int s0, a0, f0, c0, g, lo, hi, stray;
    bit det;
    det = exp_detect(len, thr);
    sync_thresh = CW'(thr);
    ack_pend = ackp;
    s0 = n_soft; a0 = n_abort; f0 = n_fall; c0 = n_clash;
    @(negedge clk);
    host_low = 1'b1;
    repeat (len * DIV) @(negedge clk);
    host_low = 1'b0;
    if (det) begin
      g = 0;
      while (!pad_oe && g < 4000) begin @(negedge clk); g++; end
      check(g >= GAP_LEN * DIV && g <= (GAP_LEN + 1) * DIV + 6,
            {tag, " R4 gap clocks"}, g, GAP_LEN * DIV);
      lo = 0;
      while (pad_oe && !pad_out && lo < 4000) begin @(negedge clk); lo++; end
      check(lo == LOW_LEN * DIV, {tag, " R5 low clocks"}, lo, LOW_LEN * DIV);
      hi = 0;
      while (pad_oe && pad_out && hi < 4000) begin @(negedge clk); hi++; end
      check(hi == DIV, {tag, " R6 high clocks"}, hi, DIV);
      check(!pad_oe, {tag, " R6 released"}, int'(pad_oe), 0);
    end else begin
      stray = 0;
      repeat ((GAP_LEN + LOW_LEN / 8) * DIV) begin
        @(negedge clk);
        if (pad_oe) stray++;
      end
      check(stray == 0, {tag, " R2 no drive on short low"}, stray, 0);
    end
    repeat (6) @(negedge clk);
    check(n_soft - s0 == int'(det), {tag, " R2 soft_rst count"}, n_soft - s0, int'(det));
    check(n_abort - a0 == int'(det && ackp), {tag, " R7 ack_abort count"},
          n_abort - a0, int'(det && ackp));
    check(n_fall - f0 == 1, {tag, " R8 host_fall count"}, n_fall - f0, 1);
    check(n_clash == c0, {tag, " R4 drive while host low"}, n_clash - c0, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd5150));
    repeat (4) @(negedge clk);
    check(!pad_oe && !pad_out && !soft_rst && !ack_abort && !host_fall,
          "R1 outputs in reset", int'({pad_oe, pad_out, soft_rst, ack_abort, host_fall}), 0);
    rst = 1'b0;
    @(negedge clk);
    check(!pad_oe && !soft_rst && !host_fall, "R1 after reset",
          int'({pad_oe, soft_rst, host_fall}), 0);
    repeat (8) @(negedge clk);

    run_trial(140, 128, 1'b0, "R2 nominal");
    run_trial(120, 128, 1'b0, "R2 short");
    run_trial(130, 128, 1'b1, "R7 ack pending");
    run_trial(10, 8, 1'b0, "R9 back-to-back A");
    run_trial(12, 8, 1'b1, "R9 back-to-back B");
    run_trial(300, 250, 1'b0, "R3 saturate");
    run_trial(400, 255, 1'b1, "R3 full scale");
    run_trial(3, 40, 1'b0, "R8 brief glitch");

    for (int i = 0; i < 20; i++) begin
      int thr, len;
      bit ackp;
      thr = 8 + int'($urandom % 193);
      len = 2 + int'($urandom % 258);
      if (len > thr - 2 && len < thr + 2) len = thr + 2;
      ackp = 1'($urandom);
      run_trial(len, thr, ackp, "random");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule